// File: doc/BRIEF.md
# Operand Forwarding Unit

This block picks where each operand of a five-stage integer pipeline comes from. Each cycle it compares the two source register numbers of the instruction in the execute stage with the destination registers held in the two later pipeline registers: execute-to-memory and memory-to-writeback. From that it drives a select for each ALU operand multiplexer. It also drives a select for the write-data input of data memory, which a store in the memory stage uses. The operand and store-data multiplexers are inside the block, so the selected values appear at the ports next to their selects.

The unit has no state. When a load in the memory stage feeds an ALU source of the next instruction, the value is not ready in time. The unit then raises a stall request, and the pipeline control uses it to hold the execute stage for a cycle. A register file that writes before it reads in the same cycle serves a reader three instructions behind its writer, so that case needs no forwarding path.

Top module: `fwd_unit`

## Requirements
- R1: When no later stage holds a matching write, the operand select is 0 (register file) and the operand equals the register-file value.
- R2: When the execute-to-memory stage holds a valid, non-load instruction that writes the source register, the select is 1 and the operand equals that stage's ALU result.
- R3: When only the memory-to-writeback stage holds a valid, non-load instruction that writes the source register, the select is 2 and the operand equals that stage's ALU result.
- R4: When only the memory-to-writeback stage holds a valid load that writes the source register, the select is 3 and the operand equals the load data.
- R5: When both later stages write the source register, the execute-to-memory stage (the newer result) is chosen.
- R6: Register 0 never produces a match, in either stage or for either source.
- R7: A stage whose valid bit or write flag is clear never produces a match.
- R8: The two ALU operands are resolved independently of each other.
- R9: A valid load in the execute-to-memory stage that writes an ALU source of a valid execute instruction raises stall_o. That load is never used as a forwarding source; the operand falls back to the memory-to-writeback stage or to the register file.
- R10: When the execute instruction is a store, a match on its second source (store data, needed only in the memory stage) does not raise stall_o. A match on its first source (the address base) still raises it.
- R11: For a valid store in the memory stage whose data register is written by a valid memory-to-writeback instruction (register 0 excluded), the store select is 1. The store data is then the load data if that instruction is a load and its ALU result otherwise. In every other case the select is 0 and the store data passes through.
- R12: stall_o is 0 whenever the execute stage is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_valid_i | input | 1 | Execute stage holds an instruction |
| ex_store_i | input | 1 | Execute instruction is a store |
| ex_rs1_i | input | RW | First source register number |
| ex_rs2_i | input | RW | Second source register number |
| rf_rs1_data_i | input | XLEN | Register-file value for first source |
| rf_rs2_data_i | input | XLEN | Register-file value for second source |
| exm_valid_i | input | 1 | Execute-to-memory stage valid |
| exm_wr_i | input | 1 | Execute-to-memory instruction writes a register |
| exm_load_i | input | 1 | Execute-to-memory instruction is a load |
| exm_store_i | input | 1 | Execute-to-memory instruction is a store |
| exm_rd_i | input | RW | Execute-to-memory destination register |
| exm_st_rs_i | input | RW | Store-data register of the store in the memory stage |
| exm_alu_i | input | XLEN | Execute-to-memory ALU result |
| exm_st_data_i | input | XLEN | Store data carried from the execute stage |
| mwb_valid_i | input | 1 | Memory-to-writeback stage valid |
| mwb_wr_i | input | 1 | Memory-to-writeback instruction writes a register |
| mwb_load_i | input | 1 | Memory-to-writeback instruction is a load |
| mwb_rd_i | input | RW | Memory-to-writeback destination register |
| mwb_alu_i | input | XLEN | Memory-to-writeback ALU result |
| mwb_ld_i | input | XLEN | Memory-to-writeback load data |
| opa_sel_o | output | 2 | First operand select (0 RF, 1 EX/MEM ALU, 2 MEM/WB ALU, 3 MEM/WB load) |
| opb_sel_o | output | 2 | Second operand select, same encoding |
| opa_o | output | XLEN | First ALU operand |
| opb_o | output | XLEN | Second ALU operand |
| st_sel_o | output | 1 | Store-data select (1 = forwarded) |
| st_data_o | output | XLEN | Data-memory write data |
| stall_o | output | 1 | Load-use stall request |

## Verification
A table of pipeline snapshots tries the operand selection with five kinds of source: no writer, a newer ALU writer, an older ALU writer, an older load, and both stages matching. Each ALU-side source drives a different data value, so the checked operand shows which path was taken and not only the select code. Register 0, bubbles and cleared write flags are placed at register numbers that would otherwise match, which separates real matches from false ones. Load-use cases vary the instruction kind and the source position, so a stall on store data can be told apart from a stall on the address base. Directed store cases switch the older writer between load and ALU and gate the store itself.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF      = 2'd0,
    SEL_EXM_ALU = 2'd1,
    SEL_MWB_ALU = 2'd2,
    SEL_MWB_LD  = 2'd3
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int unsigned RW = 5
) (
  input  logic          valid_i,
  input  logic          wr_i,
  input  logic [RW-1:0] rd_i,
  input  logic [RW-1:0] src_i,
  output logic          hit_o
);
  // register 0 is hardwired and never forwarded
  assign hit_o = valid_i & wr_i & (rd_i != '0) & (rd_i == src_i);
endmodule

// File: rtl/fwd_alu_sel.sv
module fwd_alu_sel
  import fwd_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic          [RW-1:0] src_i,
  input  logic                   exm_valid_i,
  input  logic                   exm_wr_i,
  input  logic                   exm_load_i,
  input  logic          [RW-1:0] exm_rd_i,
  input  logic                   mwb_valid_i,
  input  logic                   mwb_wr_i,
  input  logic                   mwb_load_i,
  input  logic          [RW-1:0] mwb_rd_i,
  output fwd_sel_e               sel_o,
  output logic                   ld_use_o
);
  logic exm_hit, mwb_hit;

  fwd_match #(.RW(RW)) u_exm (
    .valid_i(exm_valid_i), .wr_i(exm_wr_i), .rd_i(exm_rd_i),
    .src_i(src_i), .hit_o(exm_hit)
  );
  fwd_match #(.RW(RW)) u_mwb (
    .valid_i(mwb_valid_i), .wr_i(mwb_wr_i), .rd_i(mwb_rd_i),
    .src_i(src_i), .hit_o(mwb_hit)
  );

  // load data in EX/MEM is not ready yet: no bypass, request a stall
  assign ld_use_o = exm_hit & exm_load_i;

  always_comb begin
    sel_o = SEL_RF;
    if (exm_hit && !exm_load_i) sel_o = SEL_EXM_ALU;
    else if (mwb_hit)           sel_o = mwb_load_i ? SEL_MWB_LD : SEL_MWB_ALU;
  end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
  parameter int unsigned RW   = 5,
  parameter int unsigned XLEN = 32
) (
  input  logic            exm_valid_i,
  input  logic            exm_store_i,
  input  logic [RW-1:0]   exm_st_rs_i,
  input  logic [XLEN-1:0] exm_st_data_i,
  input  logic            mwb_valid_i,
  input  logic            mwb_wr_i,
  input  logic            mwb_load_i,
  input  logic [RW-1:0]   mwb_rd_i,
  input  logic [XLEN-1:0] mwb_alu_i,
  input  logic [XLEN-1:0] mwb_ld_i,
  output logic            sel_o,
  output logic [XLEN-1:0] data_o
);
  logic hit;

  fwd_match #(.RW(RW)) u_mwb (
    .valid_i(mwb_valid_i), .wr_i(mwb_wr_i), .rd_i(mwb_rd_i),
    .src_i(exm_st_rs_i), .hit_o(hit)
  );

  assign sel_o  = exm_valid_i & exm_store_i & hit;
  assign data_o = !sel_o    ? exm_st_data_i :
                  mwb_load_i ? mwb_ld_i : mwb_alu_i;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic            ex_valid_i,
  input  logic            ex_store_i,
  input  logic [RW-1:0]   ex_rs1_i,
  input  logic [RW-1:0]   ex_rs2_i,
  input  logic [XLEN-1:0] rf_rs1_data_i,
  input  logic [XLEN-1:0] rf_rs2_data_i,
  input  logic            exm_valid_i,
  input  logic            exm_wr_i,
  input  logic            exm_load_i,
  input  logic            exm_store_i,
  input  logic [RW-1:0]   exm_rd_i,
  input  logic [RW-1:0]   exm_st_rs_i,
  input  logic [XLEN-1:0] exm_alu_i,
  input  logic [XLEN-1:0] exm_st_data_i,
  input  logic            mwb_valid_i,
  input  logic            mwb_wr_i,
  input  logic            mwb_load_i,
  input  logic [RW-1:0]   mwb_rd_i,
  input  logic [XLEN-1:0] mwb_alu_i,
  input  logic [XLEN-1:0] mwb_ld_i,
  output logic [1:0]      opa_sel_o,
  output logic [1:0]      opb_sel_o,
  output logic [XLEN-1:0] opa_o,
  output logic [XLEN-1:0] opb_o,
  output logic            st_sel_o,
  output logic [XLEN-1:0] st_data_o,
  output logic            stall_o
);
  localparam int unsigned NOPS = 2;

  logic [RW-1:0]   src     [NOPS];
  logic [XLEN-1:0] rf_data [NOPS];
  fwd_sel_e        sel     [NOPS];
  logic [XLEN-1:0] op      [NOPS];
  logic [NOPS-1:0] ld_use;

  assign src[0]     = ex_rs1_i;
  assign src[1]     = ex_rs2_i;
  assign rf_data[0] = rf_rs1_data_i;
  assign rf_data[1] = rf_rs2_data_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fwd_alu_sel #(.RW(RW)) u_sel (
      .src_i      (src[g]),
      .exm_valid_i(exm_valid_i),
      .exm_wr_i   (exm_wr_i),
      .exm_load_i (exm_load_i),
      .exm_rd_i   (exm_rd_i),
      .mwb_valid_i(mwb_valid_i),
      .mwb_wr_i   (mwb_wr_i),
      .mwb_load_i (mwb_load_i),
      .mwb_rd_i   (mwb_rd_i),
      .sel_o      (sel[g]),
      .ld_use_o   (ld_use[g])
    );

    always_comb begin
      unique case (sel[g])
        SEL_EXM_ALU: op[g] = exm_alu_i;
        SEL_MWB_ALU: op[g] = mwb_alu_i;
        SEL_MWB_LD:  op[g] = mwb_ld_i;
        default:     op[g] = rf_data[g];
      endcase
    end
  end

  assign opa_sel_o = sel[0];
  assign opb_sel_o = sel[1];
  assign opa_o     = op[0];
  assign opb_o     = op[1];

  // store data of an EX store is picked up later by the MEM-stage path
  assign stall_o = ex_valid_i & (ld_use[0] | (ld_use[1] & ~ex_store_i));

  fwd_store_sel #(.RW(RW), .XLEN(XLEN)) u_st (
    .exm_valid_i  (exm_valid_i),
    .exm_store_i  (exm_store_i),
    .exm_st_rs_i  (exm_st_rs_i),
    .exm_st_data_i(exm_st_data_i),
    .mwb_valid_i  (mwb_valid_i),
    .mwb_wr_i     (mwb_wr_i),
    .mwb_load_i   (mwb_load_i),
    .mwb_rd_i     (mwb_rd_i),
    .mwb_alu_i    (mwb_alu_i),
    .mwb_ld_i     (mwb_ld_i),
    .sel_o        (st_sel_o),
    .data_o       (st_data_o)
  );
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input logic            ex_valid_i,
  input logic            ex_store_i,
  input logic [RW-1:0]   ex_rs1_i,
  input logic [RW-1:0]   ex_rs2_i,
  input logic [XLEN-1:0] rf_rs1_data_i,
  input logic [XLEN-1:0] rf_rs2_data_i,
  input logic            exm_valid_i,
  input logic            exm_wr_i,
  input logic            exm_load_i,
  input logic            exm_store_i,
  input logic [RW-1:0]   exm_rd_i,
  input logic [RW-1:0]   exm_st_rs_i,
  input logic [XLEN-1:0] exm_alu_i,
  input logic [XLEN-1:0] exm_st_data_i,
  input logic            mwb_valid_i,
  input logic            mwb_wr_i,
  input logic            mwb_load_i,
  input logic [RW-1:0]   mwb_rd_i,
  input logic [XLEN-1:0] mwb_alu_i,
  input logic [XLEN-1:0] mwb_ld_i,
  input logic [1:0]      opa_sel_o,
  input logic [1:0]      opb_sel_o,
  input logic [XLEN-1:0] opa_o,
  input logic [XLEN-1:0] opb_o,
  input logic            st_sel_o,
  input logic [XLEN-1:0] st_data_o,
  input logic            stall_o
);
  always_comb begin
    AST_OPA_RF:     assert (opa_sel_o != 2'd0 || opa_o == rf_rs1_data_i); // R1
    AST_OPA_EXM:    assert (opa_sel_o != 2'd1 || opa_o == exm_alu_i);     // R2
    AST_OPB_MWB:    assert (opb_sel_o != 2'd2 || opb_o == mwb_alu_i);     // R3
    AST_OPB_LD:     assert (opb_sel_o != 2'd3 || opb_o == mwb_ld_i);      // R4
    AST_OPA_ZERO:   assert (ex_rs1_i != '0 || opa_sel_o == 2'd0);         // R6
    AST_OPB_ZERO:   assert (ex_rs2_i != '0 || opb_sel_o == 2'd0);         // R6
    AST_EXM_BUBBLE: assert (exm_valid_i || (opa_sel_o != 2'd1 && opb_sel_o != 2'd1)); // R7
    AST_NO_EXM_LD:  assert (!exm_load_i || (opa_sel_o != 2'd1 && opb_sel_o != 2'd1)); // R9
    AST_STALL_SRC:  assert (!stall_o || (exm_valid_i && exm_load_i && exm_wr_i)); // R9
    AST_STALL_EXV:  assert (ex_valid_i || !stall_o);                      // R12
    AST_ST_GATED:   assert (!st_sel_o || (exm_valid_i && exm_store_i && mwb_valid_i)); // R11
    AST_ST_PASS:    assert (st_sel_o || st_data_o == exm_st_data_i);      // R11
  end
endmodule

bind fwd_unit fwd_unit_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (.*);

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
  localparam int XLEN = 32;
  localparam int RW   = 5;

  localparam logic [XLEN-1:0] V_RF1 = 32'hA1A1_0001;
  localparam logic [XLEN-1:0] V_RF2 = 32'hB2B2_0002;
  localparam logic [XLEN-1:0] V_EXM = 32'hC3C3_0003;
  localparam logic [XLEN-1:0] V_MWA = 32'hD4D4_0004;
  localparam logic [XLEN-1:0] V_MWL = 32'hE5E5_0005;
  localparam logic [XLEN-1:0] V_STD = 32'hF6F6_0006;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            ex_valid_i, ex_store_i;
  logic [RW-1:0]   ex_rs1_i, ex_rs2_i;
  logic [XLEN-1:0] rf_rs1_data_i, rf_rs2_data_i;
  logic            exm_valid_i, exm_wr_i, exm_load_i, exm_store_i;
  logic [RW-1:0]   exm_rd_i, exm_st_rs_i;
  logic [XLEN-1:0] exm_alu_i, exm_st_data_i;
  logic            mwb_valid_i, mwb_wr_i, mwb_load_i;
  logic [RW-1:0]   mwb_rd_i;
  logic [XLEN-1:0] mwb_alu_i, mwb_ld_i;
  logic [1:0]      opa_sel_o, opb_sel_o;
  logic [XLEN-1:0] opa_o, opb_o, st_data_o;
  logic            st_sel_o, stall_o;

  fwd_unit #(.XLEN(XLEN), .NREG(32)) u0 (.*);

  typedef struct packed {
    logic          exv, exst;
    logic [RW-1:0] rs1, rs2;
    logic          xv, xw, xl;
    logic [RW-1:0] xrd;
    logic          wv, ww, wl;
    logic [RW-1:0] wrd;
    logic [1:0]    ea, eb;
    logic          es;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0, 5'd1, 5'd2,  1'b1,1'b1,1'b0, 5'd3,  1'b1,1'b1,1'b0, 5'd4,  2'd0,2'd0,1'b0}, // R1
    '{1'b1,1'b0, 5'd5, 5'd2,  1'b1,1'b1,1'b0, 5'd5,  1'b1,1'b1,1'b0, 5'd9,  2'd1,2'd0,1'b0}, // R2
    '{1'b1,1'b0, 5'd1, 5'd7,  1'b1,1'b1,1'b0, 5'd3,  1'b1,1'b1,1'b0, 5'd7,  2'd0,2'd2,1'b0}, // R3
    '{1'b1,1'b0, 5'd8, 5'd8,  1'b1,1'b1,1'b0, 5'd3,  1'b1,1'b1,1'b1, 5'd8,  2'd3,2'd3,1'b0}, // R4
    '{1'b1,1'b0, 5'd6, 5'd6,  1'b1,1'b1,1'b0, 5'd6,  1'b1,1'b1,1'b1, 5'd6,  2'd1,2'd1,1'b0}, // R5
    '{1'b1,1'b0, 5'd0, 5'd0,  1'b1,1'b1,1'b0, 5'd0,  1'b1,1'b1,1'b1, 5'd0,  2'd0,2'd0,1'b0}, // R6
    '{1'b1,1'b0, 5'd4, 5'd4,  1'b0,1'b1,1'b0, 5'd4,  1'b1,1'b0,1'b0, 5'd4,  2'd0,2'd0,1'b0}, // R7
    '{1'b1,1'b0, 5'd4, 5'd4,  1'b1,1'b0,1'b1, 5'd4,  1'b0,1'b1,1'b1, 5'd4,  2'd0,2'd0,1'b0}, // R7
    '{1'b1,1'b0, 5'd10,5'd11, 1'b1,1'b1,1'b1, 5'd10, 1'b1,1'b1,1'b0, 5'd10, 2'd2,2'd0,1'b1}, // R9
    '{1'b1,1'b0, 5'd3, 5'd12, 1'b1,1'b1,1'b1, 5'd12, 1'b1,1'b1,1'b0, 5'd3,  2'd2,2'd0,1'b1}, // R9
    '{1'b1,1'b1, 5'd1, 5'd13, 1'b1,1'b1,1'b1, 5'd13, 1'b1,1'b1,1'b0, 5'd3,  2'd0,2'd0,1'b0}, // R10
    '{1'b1,1'b1, 5'd13,5'd2,  1'b1,1'b1,1'b1, 5'd13, 1'b1,1'b1,1'b0, 5'd3,  2'd0,2'd0,1'b1}, // R10
    '{1'b0,1'b0, 5'd13,5'd2,  1'b1,1'b1,1'b1, 5'd13, 1'b1,1'b1,1'b0, 5'd3,  2'd0,2'd0,1'b0}, // R12
    '{1'b1,1'b0, 5'd5, 5'd9,  1'b1,1'b1,1'b0, 5'd5,  1'b1,1'b1,1'b1, 5'd9,  2'd1,2'd3,1'b0}  // R8
  };
  localparam string VREQ [NV] = '{"R1","R2","R3","R4","R5","R6","R7","R7",
                                  "R9","R9","R10","R10","R12","R8"};

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  function automatic logic [XLEN-1:0] exp_val(logic [1:0] s, logic [XLEN-1:0] rfv);
    case (s)
      2'd1:    return V_EXM;
      2'd2:    return V_MWA;
      2'd3:    return V_MWL;
      default: return rfv;
    endcase
  endfunction

  task automatic check(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ex_valid_i = 0; ex_store_i = 0; ex_rs1_i = '0; ex_rs2_i = '0;
    rf_rs1_data_i = V_RF1; rf_rs2_data_i = V_RF2;
    exm_valid_i = 0; exm_wr_i = 0; exm_load_i = 0; exm_store_i = 0;
    exm_rd_i = '0; exm_st_rs_i = '0; exm_alu_i = V_EXM; exm_st_data_i = V_STD;
    mwb_valid_i = 0; mwb_wr_i = 0; mwb_load_i = 0; mwb_rd_i = '0;
    mwb_alu_i = V_MWA; mwb_ld_i = V_MWL;
  endtask

  task automatic store_case(string req, logic xv, logic xs, logic [RW-1:0] srs,
                            logic wv, logic wl, logic [RW-1:0] wrd,
                            logic esel, logic [XLEN-1:0] edata);
    idle();
    exm_valid_i = xv; exm_store_i = xs; exm_st_rs_i = srs;
    mwb_valid_i = wv; mwb_wr_i = 1'b1; mwb_load_i = wl; mwb_rd_i = wrd;
    @(negedge clk);
    check(req, "st_sel", XLEN'(st_sel_o), XLEN'(esel));
    check(req, "st_data", st_data_o, edata);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 2000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk);
    // idle state: everything from register file, no stall (R1, R12)
    check("R1", "idle opa_sel", XLEN'(opa_sel_o), '0);
    check("R1", "idle opb_sel", XLEN'(opb_sel_o), '0);
    check("R12", "idle stall", XLEN'(stall_o), '0);
    check("R11", "idle st_sel", XLEN'(st_sel_o), '0);

    for (int i = 0; i < NV; i++) begin
      idle();
      ex_valid_i  = VECS[i].exv; ex_store_i = VECS[i].exst;
      ex_rs1_i    = VECS[i].rs1; ex_rs2_i   = VECS[i].rs2;
      exm_valid_i = VECS[i].xv;  exm_wr_i   = VECS[i].xw;
      exm_load_i  = VECS[i].xl;  exm_rd_i   = VECS[i].xrd;
      mwb_valid_i = VECS[i].wv;  mwb_wr_i   = VECS[i].ww;
      mwb_load_i  = VECS[i].wl;  mwb_rd_i   = VECS[i].wrd;
      @(negedge clk);
      check(VREQ[i], $sformatf("vec%0d opa_sel", i), XLEN'(opa_sel_o), XLEN'(VECS[i].ea));
      check(VREQ[i], $sformatf("vec%0d opb_sel", i), XLEN'(opb_sel_o), XLEN'(VECS[i].eb));
      check(VREQ[i], $sformatf("vec%0d opa", i), opa_o, exp_val(VECS[i].ea, V_RF1));
      check(VREQ[i], $sformatf("vec%0d opb", i), opb_o, exp_val(VECS[i].eb, V_RF2));
      check(VREQ[i], $sformatf("vec%0d stall", i), XLEN'(stall_o), XLEN'(VECS[i].es));
    end

    // store-data path in the memory stage (R11)
    store_case("R11", 1'b1, 1'b1, 5'd4, 1'b1, 1'b1, 5'd4, 1'b1, V_MWL);
    store_case("R11", 1'b1, 1'b1, 5'd4, 1'b1, 1'b0, 5'd4, 1'b1, V_MWA);
    store_case("R11", 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, V_STD);
    store_case("R11", 1'b1, 1'b0, 5'd4, 1'b1, 1'b1, 5'd4, 1'b0, V_STD);
    store_case("R11", 1'b0, 1'b1, 5'd4, 1'b1, 1'b1, 5'd4, 1'b0, V_STD);
    store_case("R11", 1'b1, 1'b1, 5'd4, 1'b0, 1'b1, 5'd4, 1'b0, V_STD);
    store_case("R11", 1'b1, 1'b1, 5'd4, 1'b1, 1'b1, 5'd5, 1'b0, V_STD);

    // both sources stalled by an ALU-source load, even for a store's base (R10)
    idle();
    ex_valid_i = 1; ex_store_i = 1; ex_rs1_i = 5'd7; ex_rs2_i = 5'd7;
    exm_valid_i = 1; exm_wr_i = 1; exm_load_i = 1; exm_rd_i = 5'd7;
    @(negedge clk);
    check("R10", "store base+data stall", XLEN'(stall_o), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule